// File: doc/BRIEF.md
# Load-Miss Merging Buffer with Miss Accounting

This block sits between a level-one data cache and the level-two cache. It holds a small pool of outstanding line fetches. Every load miss that the core presents is compared, by line address, against every line currently in flight. A line that is not yet in flight takes a free slot, and that slot sends exactly one fetch to level two. A miss to a line that is already in flight joins the existing slot. The block records the requester's tag there and sends nothing further downstream. When the fill comes back, the slot answers each of its requesters in turn and then becomes free again.

Three running counters show the effect of the merging: all accepted misses, misses that were merged into an existing slot, and fetches committed toward level two. The third always equals the first minus the second. The core sees back-pressure through a ready signal; a request is never dropped.

Top module: `miss_merge_buf`

## Requirements
- R1: Two addresses belong to the same line when they agree on every bit from bit 6 upward (64-byte lines); the low six bits never affect matching.
- R2: A miss whose line is not in flight takes a free slot and causes exactly one level-two request carrying the line address (address bits 6 and up) and the slot number as its id.
- R3: A miss whose line is in flight and whose fetch has not yet returned is merged into that slot and produces no level-two request.
- R4: When the fill for a slot returns, that slot issues one completion per cycle carrying the fill data, with the requester tags in the order they were accepted, and is then freed.
- R5: When all four slots are busy and a miss arrives for a line not in flight, req_ready is low and the request is held until a slot frees, then accepted; it is never lost.
- R6: A miss to an in-flight line is held off (req_ready low) when that slot already holds eight requesters, or when that slot's fill has returned and it is still answering requesters.
- R7: The total-miss counter increases by one for every accepted request, merged or not.
- R8: The merged-miss counter increases for each merged request, the level-two counter for each slot allocation, and at every cycle the level-two count equals the total count minus the merged count.
- R9: While a level-two request is offered and not accepted, its valid, line and id stay unchanged.
- R10: After reset all counters are zero, req_ready is high, and neither l2_req_valid nor cmp_valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a load miss |
| req_ready | output | 1 | Miss accepted this cycle when high together with req_valid |
| req_addr | input | 32 | Byte address of the miss |
| req_tag | input | 6 | Requester tag returned with the completion |
| l2_req_valid | output | 1 | Level-two fetch offered |
| l2_req_ready | input | 1 | Level two takes the fetch |
| l2_req_line | output | 26 | Line address of the fetch |
| l2_req_id | output | 2 | Slot number of the fetch |
| l2_rsp_valid | input | 1 | Fill returns from level two |
| l2_rsp_id | input | 2 | Slot number the fill belongs to |
| l2_rsp_data | input | 64 | Fill data |
| cmp_valid | output | 1 | Completion to the core |
| cmp_tag | output | 6 | Tag of the completed requester |
| cmp_data | output | 64 | Data for the completed requester |
| cnt_l1_miss | output | 16 | Accepted misses |
| cnt_merged | output | 16 | Merged misses |
| cnt_l2_req | output | 16 | Level-two fetches committed |

## Verification
The assertions take for granted that level two returns a fill only for a slot whose fetch it has already accepted and not yet answered, and that it returns at most one fill per slot per fetch. The bench's level-two model keeps a queue of the fetches it has taken and answers only from that queue, in order and after a fixed latency, so each id it returns names a slot that is waiting. Its ready line is toggled in one phase to exercise the hold rule, and a hold flag lets the tests keep every slot busy on purpose.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_PEND  = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_DRAIN = 2'd3
  } slot_state_e;

  localparam int unsigned LINE_OFF = 6;

endpackage

// File: rtl/mmb_pick.sv
module mmb_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/mmb_slot.sv
module mmb_slot
  import mmb_pkg::*;
#(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_TAG  = 8,
  localparam int unsigned CW = $clog2(N_TAG + 1),
  localparam int unsigned PW = (N_TAG > 1) ? $clog2(N_TAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              issue_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              pop_i,
  output slot_state_e       state_o,
  output logic [LINE_W-1:0] line_o,
  output logic              full_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [DATA_W-1:0] data_o
);

  slot_state_e       state_q, state_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [PW-1:0]     rd_q, rd_d;
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  tags_q [N_TAG];
  logic              tag_we;
  logic [PW-1:0]     tag_wsel;
  logic              data_we;
  logic              line_we;

  always_comb begin
    state_d  = state_q;
    line_d   = line_q;
    cnt_d    = cnt_q;
    rd_d     = rd_q;
    tag_we   = 1'b0;
    tag_wsel = '0;
    data_we  = 1'b0;
    line_we  = 1'b0;
    unique case (state_q)
      SLOT_FREE: begin
        if (alloc_i) begin
          state_d = SLOT_PEND;
          line_d  = line_i;
          line_we = 1'b1;
          cnt_d   = CW'(1);
          rd_d    = '0;
          tag_we  = 1'b1;
        end
      end
      SLOT_PEND: begin
        if (issue_i) state_d = SLOT_WAIT;
        if (merge_i) begin
          tag_we   = 1'b1;
          tag_wsel = PW'(cnt_q);
          cnt_d    = cnt_q + CW'(1);
        end
      end
      SLOT_WAIT: begin
        if (fill_i) begin
          state_d = SLOT_DRAIN;
          data_we = 1'b1;
        end
        if (merge_i) begin
          tag_we   = 1'b1;
          tag_wsel = PW'(cnt_q);
          cnt_d    = cnt_q + CW'(1);
        end
      end
      SLOT_DRAIN: begin
        if (pop_i) begin
          if ((CW'(rd_q) + CW'(1)) == cnt_q) state_d = SLOT_FREE;
          else                               rd_d    = rd_q + PW'(1);
        end
      end
      default: state_d = SLOT_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      cnt_q   <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (line_we) line_q <= line_d;
    if (data_we) data_q <= fill_data_i;
  end

  for (genvar g = 0; g < N_TAG; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (tag_we && (tag_wsel == PW'(g))) tags_q[g] <= tag_i;
    end
  end

  assign state_o    = state_q;
  assign line_o     = line_q;
  assign full_o     = (cnt_q == CW'(N_TAG));
  assign head_tag_o = tags_q[rd_q];
  assign data_o     = data_q;

  AST_FILL_TO_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |-> state_q == SLOT_WAIT);                                   // R4
  AST_ISSUE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> state_q == SLOT_PEND);                                  // R2
  AST_NO_TAG_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> !full_o && (state_q == SLOT_PEND || state_q == SLOT_WAIT)); // R6
  AST_POP_ONLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> state_q == SLOT_DRAIN);                                   // R4

endmodule

// File: rtl/mmb_counters.sv
module mmb_counters #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_all_i,
  input  logic             inc_merge_i,
  input  logic             inc_fwd_i,
  output logic [CNT_W-1:0] all_o,
  output logic [CNT_W-1:0] merge_o,
  output logic [CNT_W-1:0] fwd_o
);

  logic [CNT_W-1:0] all_q, all_d;
  logic [CNT_W-1:0] merge_q, merge_d;
  logic [CNT_W-1:0] fwd_q, fwd_d;

  always_comb begin
    all_d   = inc_all_i   ? all_q   + CNT_W'(1) : all_q;
    merge_d = inc_merge_i ? merge_q + CNT_W'(1) : merge_q;
    fwd_d   = inc_fwd_i   ? fwd_q   + CNT_W'(1) : fwd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_q   <= '0;
      merge_q <= '0;
      fwd_q   <= '0;
    end else begin
      all_q   <= all_d;
      merge_q <= merge_d;
      fwd_q   <= fwd_d;
    end
  end

  assign all_o   = all_q;
  assign merge_o = merge_q;
  assign fwd_o   = fwd_q;

  AST_MISS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_merge_i || inc_fwd_i) |-> inc_all_i && (inc_merge_i != inc_fwd_i)); // R7
  AST_COUNT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_q == all_q - merge_q);                                          // R8

endmodule

// File: rtl/miss_merge_buf.sv
module miss_merge_buf
  import mmb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_SLOT = 4,
  parameter int unsigned N_TAG  = 8,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF,
  localparam int unsigned ID_W   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              l2_req_valid,
  input  logic              l2_req_ready,
  output logic [LINE_W-1:0] l2_req_line,
  output logic [ID_W-1:0]   l2_req_id,
  input  logic              l2_rsp_valid,
  input  logic [ID_W-1:0]   l2_rsp_id,
  input  logic [DATA_W-1:0] l2_rsp_data,
  output logic              cmp_valid,
  output logic [TAG_W-1:0]  cmp_tag,
  output logic [DATA_W-1:0] cmp_data,
  output logic [CNT_W-1:0]  cnt_l1_miss,
  output logic [CNT_W-1:0]  cnt_merged,
  output logic [CNT_W-1:0]  cnt_l2_req
);

  logic [LINE_W-1:0] req_line;
  slot_state_e       st      [N_SLOT];
  logic [LINE_W-1:0] s_line  [N_SLOT];
  logic [TAG_W-1:0]  s_tag   [N_SLOT];
  logic [DATA_W-1:0] s_data  [N_SLOT];
  logic [N_SLOT-1:0] s_full;
  logic [N_SLOT-1:0] match_vec, mergeable_vec, free_vec, pend_vec, drain_vec;
  logic [N_SLOT-1:0] alloc_vec, merge_vec, issue_vec, fill_vec, pop_vec;
  logic              hit, hit_ok, accept;
  logic              free_any, pend_any, drain_any;
  logic [ID_W-1:0]   free_idx, pend_idx, drain_idx, sel_idx;
  logic              lock_q, lock_d;
  logic [ID_W-1:0]   lock_idx_q, lock_idx_d;

  assign req_line = req_addr[ADDR_W-1:LINE_OFF];

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    mmb_slot #(
      .LINE_W (LINE_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .N_TAG  (N_TAG)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_vec[s]),
      .merge_i     (merge_vec[s]),
      .line_i      (req_line),
      .tag_i       (req_tag),
      .issue_i     (issue_vec[s]),
      .fill_i      (fill_vec[s]),
      .fill_data_i (l2_rsp_data),
      .pop_i       (pop_vec[s]),
      .state_o     (st[s]),
      .line_o      (s_line[s]),
      .full_o      (s_full[s]),
      .head_tag_o  (s_tag[s]),
      .data_o      (s_data[s])
    );

    assign free_vec[s]      = (st[s] == SLOT_FREE);
    assign pend_vec[s]      = (st[s] == SLOT_PEND);
    assign drain_vec[s]     = (st[s] == SLOT_DRAIN);
    assign mergeable_vec[s] = (st[s] == SLOT_PEND) || (st[s] == SLOT_WAIT);
    assign match_vec[s]     = (st[s] != SLOT_FREE) && (s_line[s] == req_line);
    assign fill_vec[s]      = l2_rsp_valid && (l2_rsp_id == ID_W'(s));
    assign alloc_vec[s]     = accept && !hit && (free_idx == ID_W'(s));
    assign merge_vec[s]     = accept && hit && match_vec[s];
    assign issue_vec[s]     = l2_req_valid && l2_req_ready && (sel_idx == ID_W'(s));
    assign pop_vec[s]       = drain_any && (drain_idx == ID_W'(s));
  end

  mmb_pick #(.N(N_SLOT)) u_pick_free (
    .vec_i (free_vec),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  mmb_pick #(.N(N_SLOT)) u_pick_pend (
    .vec_i (pend_vec),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  mmb_pick #(.N(N_SLOT)) u_pick_drain (
    .vec_i (drain_vec),
    .any_o (drain_any),
    .idx_o (drain_idx)
  );

  // Core side acceptance.
  assign hit       = |match_vec;
  assign hit_ok    = |(match_vec & mergeable_vec & ~s_full);
  assign req_ready = hit ? hit_ok : free_any;
  assign accept    = req_valid && req_ready;

  // Level-two issue with a lock that pins the offered slot while stalled.
  assign sel_idx      = lock_q ? lock_idx_q : pend_idx;
  assign l2_req_valid = lock_q || pend_any;
  assign l2_req_line  = s_line[sel_idx];
  assign l2_req_id    = sel_idx;

  always_comb begin
    lock_d     = l2_req_valid && !l2_req_ready;
    lock_idx_d = lock_d ? sel_idx : lock_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
    end
  end

  // Completion side.
  assign cmp_valid = drain_any;
  assign cmp_tag   = s_tag[drain_idx];
  assign cmp_data  = s_data[drain_idx];

  mmb_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_all_i   (accept),
    .inc_merge_i (accept && hit),
    .inc_fwd_i   (|alloc_vec),
    .all_o       (cnt_l1_miss),
    .merge_o     (cnt_merged),
    .fwd_o       (cnt_l2_req)
  );

  AST_ONE_SLOT_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));                                               // R3
  AST_L2_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid && !l2_req_ready |=> l2_req_valid && $stable(l2_req_line) && $stable(l2_req_id)); // R9
  AST_SINGLE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec) && !(|(alloc_vec & merge_vec)));                // R2
  AST_ISSUED_SLOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid |-> st[sel_idx] == SLOT_PEND);                         // R9

endmodule

// File: tb/miss_merge_buf_tb.sv
module miss_merge_buf_tb;

  typedef struct { logic [5:0] tag; logic [25:0] line; } exp_t;
  typedef struct { logic [1:0] id; logic [25:0] line; int t; } l2_t;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [5:0]  req_tag;
  logic        l2_req_valid, l2_req_ready;
  logic [25:0] l2_req_line;
  logic [1:0]  l2_req_id;
  logic        l2_rsp_valid;
  logic [1:0]  l2_rsp_id;
  logic [63:0] l2_rsp_data;
  logic        cmp_valid;
  logic [5:0]  cmp_tag;
  logic [63:0] cmp_data;
  logic [15:0] cnt_l1_miss, cnt_merged, cnt_l2_req;

  int n_chk, n_bad, cyc;
  int exp_l1, exp_sq, exp_l2, l2_seen;
  int lat;
  bit l2_hold, l2_toggle, done;
  exp_t exp_q[$];
  l2_t  l2q[$];

  miss_merge_buf u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_tag,
    .l2_req_valid, .l2_req_ready, .l2_req_line, .l2_req_id,
    .l2_rsp_valid, .l2_rsp_id, .l2_rsp_data,
    .cmp_valid, .cmp_tag, .cmp_data,
    .cnt_l1_miss, .cnt_merged, .cnt_l2_req
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] fill_of(logic [25:0] ln);
    return {32'hFEED_0000, 6'b0, ln};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Level-two model: accepts fetches, answers in order after a latency.
  logic        prev_stall;
  logic [25:0] prev_line;
  logic [1:0]  prev_id;
  initial begin
    l2_req_ready = 1'b1;
    l2_rsp_valid = 1'b0;
    l2_rsp_id    = '0;
    l2_rsp_data  = '0;
    prev_stall   = 1'b0;
    prev_line    = '0;
    prev_id      = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall)
          chk(l2_req_valid && l2_req_line == prev_line && l2_req_id == prev_id,
              "R9", "held request", {l2_req_valid, l2_req_line}, {1'b1, prev_line});
        l2_rsp_valid = 1'b0;
        if (!l2_hold && l2q.size() > 0 && cyc >= l2q[0].t + lat) begin
          l2_rsp_valid = 1'b1;
          l2_rsp_id    = l2q[0].id;
          l2_rsp_data  = fill_of(l2q[0].line);
          void'(l2q.pop_front());
        end
        l2_req_ready = !(l2_toggle && (cyc % 3 == 1));
        prev_stall   = l2_req_valid && !l2_req_ready;
        prev_line    = l2_req_line;
        prev_id      = l2_req_id;
        if (l2_req_valid && l2_req_ready) begin
          bit dup = 1'b0;
          foreach (l2q[i]) if (l2q[i].line == l2_req_line) dup = 1'b1;
          chk(!dup, "R2", "single fetch per line", l2_req_line, 0);
          l2q.push_back('{l2_req_id, l2_req_line, cyc});
          l2_seen++;
        end
      end
    end
  end

  // Monitor: scoreboard of completions and running counter checks.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (cmp_valid) begin
          int idx = -1;
          for (int i = 0; i < exp_q.size(); i++)
            if (idx < 0 && fill_of(exp_q[i].line) == cmp_data) idx = i;
          if (idx < 0) chk(1'b0, "R4", "unexpected completion data", cmp_data, 0);
          else begin
            chk(cmp_tag == exp_q[idx].tag, "R4", "completion order tag", cmp_tag, exp_q[idx].tag);
            exp_q.delete(idx);
          end
        end
        chk(cnt_l1_miss == 16'(exp_l1), "R7", "total misses", cnt_l1_miss, exp_l1);
        chk(cnt_merged  == 16'(exp_sq), "R8", "merged misses", cnt_merged, exp_sq);
        chk(cnt_l2_req  == 16'(exp_l2), "R8", "l2 count", cnt_l2_req, exp_l2);
        chk(cnt_l2_req == cnt_l1_miss - cnt_merged, "R8", "balance", cnt_l2_req,
            cnt_l1_miss - cnt_merged);
      end
    end
  end

  // Driver: presents one miss, predicts its fate at acceptance.
  task automatic send(input logic [31:0] a, input logic [5:0] t, output int stalls);
    bit merged;
    stalls = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_tag   = t;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    merged = 1'b0;
    foreach (exp_q[i]) if (exp_q[i].line == a[31:6]) merged = 1'b1;
    exp_l1++;
    if (merged) exp_sq++;
    else        exp_l2++;
    exp_q.push_back('{t, a[31:6]});
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() > 0 || l2q.size() > 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int st;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_tag = '0;
    n_chk = 0; n_bad = 0; cyc = 0; exp_l1 = 0; exp_sq = 0; exp_l2 = 0;
    l2_seen = 0; lat = 3; l2_hold = 1'b0; l2_toggle = 1'b0; done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(cnt_l1_miss == 0 && cnt_merged == 0 && cnt_l2_req == 0, "R10", "counters",
        {cnt_l1_miss, cnt_merged, cnt_l2_req}, 0);
    chk(req_ready, "R10", "req_ready", req_ready, 1);
    chk(!l2_req_valid && !cmp_valid, "R10", "valids", {l2_req_valid, cmp_valid}, 0);

    // R2 single miss
    send(32'h0000_1000, 6'd1, st);
    wait_idle();
    chk(l2_seen == 1, "R2", "one fetch", l2_seen, 1);

    // R1 R3 R4 merging with different offsets in a line, plus a neighbour line
    l2_hold = 1'b1;
    send(32'h0000_2000, 6'd2, st);
    send(32'h0000_2008, 6'd3, st);
    send(32'h0000_203F, 6'd4, st);
    send(32'h0000_2040, 6'd5, st);
    repeat (4) @(negedge clk);
    chk(l2_seen == 3, "R3", "merged misses not forwarded", l2_seen, 3);
    chk(exp_sq == 2, "R1", "offsets share a line", exp_sq, 2);
    l2_hold = 1'b0;
    wait_idle();

    // R5 all slots busy, new line back-pressured then accepted
    l2_hold = 1'b1;
    for (int i = 0; i < 4; i++) send(32'h0001_0000 + 32'(i) * 32'h100, 6'(10 + i), st);
    fork
      send(32'h0002_0000, 6'd20, st);
      begin
        repeat (10) @(negedge clk);
        #2;
        chk(req_valid && !req_ready, "R5", "ready low when full", req_ready, 0);
        l2_hold = 1'b0;
      end
    join
    chk(st >= 10, "R5", "stall length", st, 10);
    wait_idle();
    chk(l2_seen == exp_l2, "R5", "held request fetched", l2_seen, exp_l2);

    // R6 tag overflow on one slot
    l2_hold = 1'b1;
    for (int i = 0; i < 8; i++) send(32'h0003_0000 + 32'(i) * 4, 6'(30 + i), st);
    fork
      send(32'h0003_0020, 6'd40, st);
      begin
        repeat (6) @(negedge clk);
        #2;
        chk(req_valid && !req_ready, "R6", "ready low when slot full", req_ready, 0);
        l2_hold = 1'b0;
      end
    join
    chk(st >= 6, "R6", "overflow stall", st, 6);
    wait_idle();

    // R6 draining slot holds off a same-line miss
    l2_hold = 1'b1;
    for (int i = 0; i < 3; i++) send(32'h0004_0000 + 32'(i), 6'(45 + i), st);
    l2_hold = 1'b0;
    do @(negedge clk); while (!cmp_valid);
    send(32'h0004_0010, 6'd50, st);
    chk(st >= 1, "R6", "drain stall", st, 1);
    wait_idle();

    // R9 R4 mixed traffic with a toggling level-two ready
    l2_toggle = 1'b1;
    lat = 5;
    for (int i = 0; i < 40; i++)
      send(32'h0005_0000 + 32'(i % 6) * 64 + 32'((i * 8) % 64), 6'(i), st);
    wait_idle();
    l2_toggle = 1'b0;
    chk(l2_seen == exp_l2, "R8", "fetches equal allocations", l2_seen, exp_l2);
    chk(exp_sq > 0, "R3", "merges in mixed traffic", exp_sq, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule